// File: doc/BRIEF.md
# Non-Overlapping Serial Pattern Detector

This block watches a one-bit serial stream, taking one bit on each rising clock edge, and looks for the four-bit sequence 0, 0, 1, 0 (earliest bit first). Each time the sequence completes, it raises a registered output for exactly one clock cycle.

Detection does not overlap. The bits of a completed match are used up, so the search starts again from nothing. The closing 0 of one match can never act as the opening 0 of the next one. When a partial match breaks without completing, the search keeps the longest tail of the bits already seen that is also a head of the sequence. This means extra leading zeros do not lose progress. A synchronous reset drops any partial progress.

Top module: `seqdet_0010`

## Requirements
- R1: While `rst` is high at a rising edge, `hit` is low in the following cycle and all partial progress is discarded.
- R2: When the bits 0, 0, 1, 0 are sampled on four consecutive edges (first bit first) and none of them belongs to an earlier match, `hit` is high in the cycle that follows the edge that sampled the final 0.
- R3: `hit` is high for exactly one cycle per match and never on two consecutive cycles.
- R4: The stream 0,0,1,0,0,0,1,0 produces exactly two pulses, after the 4th and the 8th bit.
- R5: The stream 0,0,1,0,0,1,0 produces exactly one pulse, because the final 0 of a match may not start the next match.
- R6: Zeros beyond two before a 1 keep the search at the two-zero point, so 0,0,0,0,1,0 pulses once, after the 6th bit.
- R7: A 1 that arrives after nothing or after a single 0, or a second 1 after 0,0,1, returns the search to its empty point. For example, 0,1,0,1,0 and 0,0,1,1,0 produce no pulse.
- R8: A reset that arrives partway through a pattern cancels it. After 0,0,1 then reset then 0, no pulse appears.

Detail on when `hit` rises: the edge that samples the final 0 of a match is also the edge that sets `hit`, so `hit` is high during the next cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| din | input | 1 | Serial data bit, sampled each rising edge |
| hit | output | 1 | One-cycle registered pulse per non-overlapping match |

## Verification
The block has a fixed four-bit sequence and no size parameters, so the bench builds it as it stands. With only four progress points and a single input bit, every possible 10-bit stream after reset can be swept, which is 1024 streams. Each of these is compared cycle by cycle with an arithmetic model that keeps a shift window and a count of bits since the last match. This reaches every transition between progress points, including matches that come back to back and matches that are broken by a mid-pattern reset. Directed streams then pin down the exact pulse counts for the overlap and the leading-zero cases.

// File: rtl/seqdet_pkg.sv
package seqdet_pkg;

    localparam int PAT_LEN = 4;
    // Bit PAT_LEN-1 is the first bit to arrive.
    localparam logic [PAT_LEN-1:0] PATTERN = 4'b0010;
    localparam int PROG_W = $clog2(PAT_LEN);

    typedef enum logic [PROG_W-1:0] {
        PG_NONE = 2'd0,
        PG_Z    = 2'd1,
        PG_ZZ   = 2'd2,
        PG_ZZO  = 2'd3
    } prog_t;

    typedef struct packed {
        prog_t nxt;
        logic  hit;
    } step_t;

    // Bit i of the sequence as seen so far: pattern head for i < cur, new bit at cur.
    function automatic logic seen_bit(input int cur, input int i, input logic b);
        if (i == cur) return b;
        return PATTERN[PAT_LEN-1-i];
    endfunction

    // One step of the search: longest tail of (head[0..cur-1], b) that is a pattern head.
    function automatic step_t advance(input prog_t cur, input logic b);
        step_t r;
        int    ci;
        int    best;
        logic  ok;
        ci   = int'(cur);
        best = 0;
        for (int k = PAT_LEN; k >= 1; k--) begin
            if (best == 0 && k <= ci + 1) begin
                ok = 1'b1;
                for (int j = 0; j < PAT_LEN; j++) begin
                    if (j < k && seen_bit(ci, ci + 1 - k + j, b) != PATTERN[PAT_LEN-1-j])
                        ok = 1'b0;
                end
                if (ok) best = k;
            end
        end
        if (best == PAT_LEN) begin
            r.hit = 1'b1;
            r.nxt = PG_NONE;
        end else begin
            r.hit = 1'b0;
            r.nxt = prog_t'(best[PROG_W-1:0]);
        end
        return r;
    endfunction

endpackage

// File: rtl/seqdet_step.sv
module seqdet_step
    import seqdet_pkg::*;
(
    input  prog_t cur,
    input  logic  bit_in,
    output step_t res
);
    always_comb begin
        res = advance(cur, bit_in);
    end
endmodule

// File: rtl/seqdet_regs.sv
module seqdet_regs
    import seqdet_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  step_t nxt,
    output prog_t prog_q,
    output logic  hit_q
);
    always_ff @(posedge clk) begin
        if (rst) begin
            prog_q <= PG_NONE;
            hit_q  <= 1'b0;
        end else begin
            prog_q <= nxt.nxt;
            hit_q  <= nxt.hit;
        end
    end
endmodule

// File: rtl/seqdet_0010.sv
module seqdet_0010
    import seqdet_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic din,
    output logic hit
);
    prog_t state_q;
    step_t step_d;

    seqdet_step u_step (
        .cur    (state_q),
        .bit_in (din),
        .res    (step_d)
    );

    seqdet_regs u_regs (
        .clk    (clk),
        .rst    (rst),
        .nxt    (step_d),
        .prog_q (state_q),
        .hit_q  (hit)
    );
endmodule

// File: rtl/seqdet_0010_chk.sv
module seqdet_0010_chk
    import seqdet_pkg::*;
(
    input logic  clk,
    input logic  rst,
    input logic  din,
    input logic  hit,
    input prog_t state
);
    // R1
    p_reset_quiet_r1: assert property (@(posedge clk) rst |=> !hit);

    // R2
    p_tail_fires_r2: assert property (@(posedge clk) disable iff (rst)
        (state == PG_ZZO && !din) |=> hit);

    // R2
    p_no_spurious_r2: assert property (@(posedge clk) disable iff (rst)
        !(state == PG_ZZO && !din) |=> !hit);

    // R3
    p_single_pulse_r3: assert property (@(posedge clk) disable iff (rst)
        hit |=> !hit);

    // R5
    p_restart_empty_r5: assert property (@(posedge clk) disable iff (rst)
        hit |-> state == PG_NONE);

    // R7
    p_one_resets_r7: assert property (@(posedge clk) disable iff (rst)
        (din && state != PG_ZZ) |=> state == PG_NONE);

    // R6
    p_zero_holds_r6: assert property (@(posedge clk) disable iff (rst)
        (!din && state == PG_ZZ) |=> state == PG_ZZ);
endmodule

bind seqdet_0010 seqdet_0010_chk u_chk (
    .clk   (clk),
    .rst   (rst),
    .din   (din),
    .hit   (hit),
    .state (state_q)
);

// File: tb/sim_seqdet_0010.sv
module sim_seqdet_0010;
    localparam int CLK_PERIOD = 10;
    localparam int SWEEP_LEN  = 10;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic din = 1'b0;
    logic hit;

    int total = 0;
    int bad   = 0;
    int fresh = 0;
    int hits  = 0;
    logic [3:0] hist = 4'b0;

    seqdet_0010 u0 (.clk(clk), .rst(rst), .din(din), .hit(hit));

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic check(input string tag, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // Drive one bit (or reset), advance the model, check hit after the edge.
    task automatic feed(input logic b, input logic r, input string tag);
        logic exp;
        @(negedge clk);
        din = b;
        rst = r;
        if (r) begin
            fresh = 0;
            hist  = 4'b0;
            exp   = 1'b0;
        end else begin
            hist = {hist[2:0], b};
            if (fresh < 4) fresh++;
            exp = (fresh >= 4) && (hist == 4'b0010);
            if (exp) fresh = 0;
        end
        @(posedge clk);
        #1;
        if (hit) hits++;
        check(tag, int'(hit), int'(exp));
    endtask

    task automatic run_stream(input logic [15:0] bits, input int len, input string tag);
        for (int i = len - 1; i >= 0; i--) feed(bits[i], 1'b0, tag);
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        bad++;
        total++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        // R1: reset state
        feed(1'b0, 1'b1, "R1 reset");
        feed(1'b0, 1'b1, "R1 reset");
        check("R1 hit low after reset", int'(hit), 0);

        // R2 / R3: single match then quiet
        feed(1'b0, 1'b1, "R1");
        hits = 0;
        run_stream(16'b0010, 4, "R2 basic");
        check("R2 basic count", hits, 1);
        feed(1'b0, 1'b0, "R3 next cycle low");

        // R4
        feed(1'b0, 1'b1, "R1");
        hits = 0;
        run_stream(16'b00100010, 8, "R4 stream");
        check("R4 count", hits, 2);

        // R5
        feed(1'b0, 1'b1, "R1");
        hits = 0;
        run_stream(16'b0010010, 7, "R5 stream");
        check("R5 count", hits, 1);

        // R6
        feed(1'b0, 1'b1, "R1");
        hits = 0;
        run_stream(16'b000010, 6, "R6 stream");
        check("R6 count", hits, 1);

        // R7
        feed(1'b0, 1'b1, "R1");
        hits = 0;
        run_stream(16'b01010, 5, "R7 stream a");
        check("R7 count a", hits, 0);
        feed(1'b0, 1'b1, "R1");
        hits = 0;
        run_stream(16'b00110, 5, "R7 stream b");
        check("R7 count b", hits, 0);

        // R8
        feed(1'b0, 1'b1, "R1");
        hits = 0;
        run_stream(16'b001, 3, "R8 head");
        feed(1'b0, 1'b1, "R8 reset");
        feed(1'b0, 1'b0, "R8 tail");
        check("R8 count", hits, 0);

        // R2: every 10-bit stream after reset
        for (int v = 0; v < (1 << SWEEP_LEN); v++) begin
            feed(1'b0, 1'b1, "R1 sweep reset");
            run_stream(16'(v), SWEEP_LEN, "R2 sweep");
        end

        // R3: long continuous run of back-to-back matches
        feed(1'b0, 1'b1, "R1");
        hits = 0;
        for (int n = 0; n < 8; n++) run_stream(16'b0010, 4, "R3 repeat");
        check("R3 repeat count", hits, 8);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule